// File: doc/BRIEF.md
# Line Transceiver Direction Controller

This block sits next to a 16550-style UART core. It decides when the RS-485/RS-422 line driver may put data on the bus and when the line receiver listens. Software writes a small control register over a byte-wide bus. That register holds a two-bit wiring selection, a master transceiver switch and a bus-termination switch. A second control byte holds an automatic-DTR enable. The block combines these with the UART's DTR output and two transmit-side activity flags to produce the driver-enable and receiver-enable pins. The two activity flags are "transmit FIFO holds data" and "shift register busy".

A read-only mode register reports what the port can do and which electrical interface it uses at present. The capability is a build-time parameter. The current interface comes from a strap input. The UART core, its FIFOs and its baud logic are outside the block, and it sees them only through input flags.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: After reset the control byte (address 0) reads 0x03, the auxiliary byte (address 1) reads 0x10, and the drv_en, rcv_en and term_en outputs are all 0.
- R2: While control bit 3 (master transceiver switch) is 0, drv_en and rcv_en are both 0 whatever the other inputs are.
- R3: With the master switch on and wiring field control[1:0] = 0 (four-wire), drv_en and rcv_en are both 1.
- R4: With the master switch on and wiring field = 1 (echo two-wire), drv_en equals uart_dtr and rcv_en is 1.
- R5: With the master switch on and wiring field = 2 (DTR-keyed two-wire), drv_en equals uart_dtr and rcv_en is the inverse of drv_en.
- R6: With the master switch on, wiring field = 3 (automatic two-wire) and auxiliary bit 4 set, drv_en is 1 while tx_fifo_nonempty or tx_shift_busy is 1. The driver therefore stays on through the final stop bit after the FIFO drains. rcv_en is the inverse of drv_en.
- R7: In automatic mode with auxiliary bit 4 clear, drv_en is 0 and rcv_en is 1.
- R8: term_en equals control bit 6 and does not depend on the master switch.
- R9: A bus write is captured on the rising edge at which bus_wr is 1. Reads are combinational. Only control bits 0, 1, 3 and 6 and auxiliary bit 4 are stored, and every other bit reads 0. Address 3 reads 0.
- R10: The mode register at address 2 reads capability code PORT_CAP in bits [1:0]: 0 none, 1 RS-232 only, 2 RS-485 only, 3 dual. Bit 4 reports the interface, 1 for RS-485 and 0 for RS-232. For a dual port bit 4 follows iface_485. For an RS-485-only port it is 1, otherwise it is 0. All other bits read 0, and writes to this address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| uart_dtr | input | 1 | DTR from the UART core, 1 = asserted |
| tx_fifo_nonempty | input | 1 | UART transmit FIFO holds at least one byte |
| tx_shift_busy | input | 1 | UART transmit shifter is sending a character |
| iface_485 | input | 1 | Strap: 1 = port is wired for RS-485 |
| drv_en | output | 1 | Line driver enable |
| rcv_en | output | 1 | Line receiver enable |
| term_en | output | 1 | Bus termination enable |

## Verification
The gating assertions assume that the DTR and transmit-activity flags are synchronous to clk and are stable around the rising edge. The bench meets this by changing every input only on the falling edge. The write-capture assertion assumes that the bus address and data are held for the whole cycle in which bus_wr is high, and the bench's write task holds them until the following falling edge. The random phase draws addresses from the full range, including the read-only and unmapped ones, so that writes to them are exercised alongside valid ones.

// File: rtl/xcvr_dir_pkg.sv
package xcvr_dir_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      WM_FULL4  = 2'd0,
      WM_ECHO   = 2'd1,
      WM_DTRKEY = 2'd2,
      WM_AUTO   = 2'd3
   } wire_mode_e;

   localparam int CTL_XCVR_BIT = 3;
   localparam int CTL_TERM_BIT = 6;
   localparam int AUX_ADTR_BIT = 4;
   localparam int MOD_IF_BIT   = 4;

   localparam logic [BYTE_W-1:0] CTL_MASK  = 8'h4B;
   localparam logic [BYTE_W-1:0] AUX_MASK  = 8'h10;
   localparam logic [BYTE_W-1:0] CTL_RESET = 8'h03;
   localparam logic [BYTE_W-1:0] AUX_RESET = 8'h10;
endpackage

// File: rtl/xdc_regs.sv
module xdc_regs
   import xcvr_dir_pkg::*;
#(
   parameter int ADDR_W   = 2,
   parameter int CTL_ADDR = 0,
   parameter int AUX_ADDR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] ctl_q,
   output logic [BYTE_W-1:0] aux_q
);
   localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_ADDR);
   localparam logic [ADDR_W-1:0] AUX_A = ADDR_W'(AUX_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
         aux_q <= AUX_RESET;
      end else if (wr) begin
         if (addr == CTL_A) ctl_q <= wdata & CTL_MASK;
         if (addr == AUX_A) aux_q <= wdata & AUX_MASK;
      end
   end

   // R9: captured value appears one edge after the strobe
   a_r9_ctl_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == CTL_A) |=> (ctl_q == ($past(wdata) & CTL_MASK)));
   a_r9_aux_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AUX_A) |=> (aux_q == ($past(wdata) & AUX_MASK)));
endmodule

// File: rtl/xdc_gate.sv
module xdc_gate
   import xcvr_dir_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       xcvr_on,
   input  logic       auto_dtr,
   input  logic       dtr,
   input  logic       fifo_ne,
   input  logic       shift_busy,
   output logic       drv,
   output logic       rcv
);
   logic tx_pending;
   logic drv_raw;
   logic rcv_raw;

   // pending covers the last stop bit after FIFO drain
   assign tx_pending = fifo_ne | shift_busy;

   always_comb begin
      unique case (wire_mode_e'(mode))
         WM_FULL4: begin
            drv_raw = 1'b1;
            rcv_raw = 1'b1;
         end
         WM_ECHO: begin
            drv_raw = dtr;
            rcv_raw = 1'b1;
         end
         WM_DTRKEY: begin
            drv_raw = dtr;
            rcv_raw = ~dtr;
         end
         default: begin
            drv_raw = auto_dtr & tx_pending;
            rcv_raw = ~(auto_dtr & tx_pending);
         end
      endcase
   end

   assign drv = xcvr_on & drv_raw;
   assign rcv = xcvr_on & rcv_raw;
endmodule

// File: rtl/xdc_rdmux.sv
module xdc_rdmux
   import xcvr_dir_pkg::*;
#(
   parameter int          ADDR_W    = 2,
   parameter int          CTL_ADDR  = 0,
   parameter int          AUX_ADDR  = 1,
   parameter int          MODE_ADDR = 2,
   parameter logic [1:0]  PORT_CAP  = 2'd3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BYTE_W-1:0] ctl_q,
   input  logic [BYTE_W-1:0] aux_q,
   input  logic              iface_485,
   output logic [BYTE_W-1:0] rdata
);
   logic if_bit;
   logic [BYTE_W-1:0] mode_val;

   generate
      if (PORT_CAP == 2'd3) begin : g_dual
         assign if_bit = iface_485;
      end else if (PORT_CAP == 2'd2) begin : g_485
         logic unused_strap;
         assign unused_strap = iface_485;
         assign if_bit = 1'b1;
      end else begin : g_other
         logic unused_strap;
         assign unused_strap = iface_485;
         assign if_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      mode_val = '0;
      mode_val[1:0] = PORT_CAP;
      mode_val[MOD_IF_BIT] = if_bit;
   end

   always_comb begin
      if (addr == ADDR_W'(CTL_ADDR))       rdata = ctl_q;
      else if (addr == ADDR_W'(AUX_ADDR))  rdata = aux_q;
      else if (addr == ADDR_W'(MODE_ADDR)) rdata = mode_val;
      else                                 rdata = '0;
   end
endmodule

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl
   import xcvr_dir_pkg::*;
#(
   parameter int         ADDR_W    = 2,
   parameter int         CTL_ADDR  = 0,
   parameter int         AUX_ADDR  = 1,
   parameter int         MODE_ADDR = 2,
   parameter logic [1:0] PORT_CAP  = 2'd3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              uart_dtr,
   input  logic              tx_fifo_nonempty,
   input  logic              tx_shift_busy,
   input  logic              iface_485,
   output logic              drv_en,
   output logic              rcv_en,
   output logic              term_en
);
   localparam int NUM_ADDR = 1 << ADDR_W;

   initial begin
      assert (ADDR_W >= 2 && ADDR_W <= 8)
         else $error("ADDR_W out of range");
      assert (CTL_ADDR < NUM_ADDR && AUX_ADDR < NUM_ADDR && MODE_ADDR < NUM_ADDR)
         else $error("register address does not fit");
      assert (CTL_ADDR != AUX_ADDR && CTL_ADDR != MODE_ADDR && AUX_ADDR != MODE_ADDR)
         else $error("register addresses overlap");
   end

   logic [BYTE_W-1:0] ctl_q;
   logic [BYTE_W-1:0] aux_q;

   xdc_regs #(
      .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .AUX_ADDR(AUX_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .ctl_q(ctl_q), .aux_q(aux_q)
   );

   xdc_gate u_gate (
      .mode(ctl_q[1:0]), .xcvr_on(ctl_q[CTL_XCVR_BIT]),
      .auto_dtr(aux_q[AUX_ADTR_BIT]), .dtr(uart_dtr),
      .fifo_ne(tx_fifo_nonempty), .shift_busy(tx_shift_busy),
      .drv(drv_en), .rcv(rcv_en)
   );

   xdc_rdmux #(
      .ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR), .AUX_ADDR(AUX_ADDR),
      .MODE_ADDR(MODE_ADDR), .PORT_CAP(PORT_CAP)
   ) u_rdmux (
      .addr(bus_addr), .ctl_q(ctl_q), .aux_q(aux_q),
      .iface_485(iface_485), .rdata(bus_rdata)
   );

   assign term_en = ctl_q[CTL_TERM_BIT];

   a_r2_master_off: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[CTL_XCVR_BIT] |-> (!drv_en && !rcv_en));
   a_r3_full_duplex: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_XCVR_BIT] && ctl_q[1:0] == 2'd0) |-> (drv_en && rcv_en));
   a_r4_echo_listen: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_XCVR_BIT] && ctl_q[1:0] == 2'd1) |-> (rcv_en && drv_en == uart_dtr));
   a_r5_r6_half_duplex: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[1] && drv_en) |-> !rcv_en);
   a_r6_hold_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[CTL_XCVR_BIT] && ctl_q[1:0] == 2'd3 && aux_q[AUX_ADTR_BIT] && tx_shift_busy)
      |-> drv_en);
   a_r7_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[1:0] == 2'd3 && !aux_q[AUX_ADTR_BIT]) |-> !drv_en);
   a_r10_mode_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(MODE_ADDR)) |-> ((bus_rdata & 8'hEC) == 8'h00));
endmodule

// File: tb/xcvr_dir_ctrl_bench.sv
module xcvr_dir_ctrl_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       uart_dtr = 1'b0;
   logic       tx_fifo_nonempty = 1'b0;
   logic       tx_shift_busy = 1'b0;
   logic       iface_485 = 1'b1;
   logic       drv_en, rcv_en, term_en;

   int n_checks = 0;
   int n_fails = 0;
   bit done = 1'b0;
   logic [7:0] m_ctl = 8'h03;
   logic [7:0] m_aux = 8'h10;

   always #(CLK_PERIOD/2) clk = ~clk;

   xcvr_dir_ctrl u_xcvr_dir_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .uart_dtr(uart_dtr),
      .tx_fifo_nonempty(tx_fifo_nonempty), .tx_shift_busy(tx_shift_busy),
      .iface_485(iface_485), .drv_en(drv_en), .rcv_en(rcv_en), .term_en(term_en)
   );

   function automatic logic exp_drv();
      if (!m_ctl[3]) return 1'b0;
      case (m_ctl[1:0])
         2'd0: return 1'b1;
         2'd1, 2'd2: return uart_dtr;
         default: return m_aux[4] & (tx_fifo_nonempty | tx_shift_busy);
      endcase
   endfunction

   function automatic logic exp_rcv();
      if (!m_ctl[3]) return 1'b0;
      case (m_ctl[1:0])
         2'd0, 2'd1: return 1'b1;
         2'd2: return ~uart_dtr;
         default: return ~(m_aux[4] & (tx_fifo_nonempty | tx_shift_busy));
      endcase
   endfunction

   function automatic logic [7:0] exp_read(input logic [1:0] a);
      case (a)
         2'd0: return m_ctl;
         2'd1: return m_aux;
         2'd2: return {3'b000, iface_485, 2'b00, 2'b11};
         default: return 8'h00;
      endcase
   endfunction

   task automatic cmp(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   function automatic string tag_for();
      if (!m_ctl[3]) return "R2";
      case (m_ctl[1:0])
         2'd0: return "R3";
         2'd1: return "R4";
         2'd2: return "R5";
         default: return m_aux[4] ? "R6" : "R7";
      endcase
   endfunction

   task automatic check_outputs();
      #1;
      cmp({tag_for(), " drv_en"}, {7'd0, drv_en}, {7'd0, exp_drv()});
      cmp({tag_for(), " rcv_en"}, {7'd0, rcv_en}, {7'd0, exp_rcv()});
      cmp("R8 term_en", {7'd0, term_en}, {7'd0, m_ctl[6]});
   endtask

   task automatic check_read(input logic [1:0] a, input string req);
      bus_addr = a;
      #1;
      cmp(req, bus_rdata, exp_read(a));
   endtask

   task automatic do_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 2'd0) m_ctl = d & 8'h4B;
      if (a == 2'd1) m_aux = d & 8'h10;
   endtask

   task automatic set_in(input logic d, input logic f, input logic s);
      @(negedge clk);
      uart_dtr = d; tx_fifo_nonempty = f; tx_shift_busy = s;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0485));
      repeat (3) @(negedge clk);
      // R1 reset state
      check_read(2'd0, "R1 ctl reset");
      check_read(2'd1, "R1 aux reset");
      cmp("R1 drv_en", {7'd0, drv_en}, 8'd0);
      cmp("R1 rcv_en", {7'd0, rcv_en}, 8'd0);
      cmp("R1 term_en", {7'd0, term_en}, 8'd0);
      @(negedge clk); rst_n = 1'b1;

      // R2 master off in auto mode with traffic
      set_in(1'b1, 1'b1, 1'b1); check_outputs();
      // R8 termination with master off
      do_write(2'd0, 8'h43); check_outputs();
      check_read(2'd0, "R9 ctl readback");
      // R9 reserved bits read zero
      do_write(2'd0, 8'hFF); check_read(2'd0, "R9 ctl reserved");
      do_write(2'd1, 8'hFF); check_read(2'd1, "R9 aux reserved");
      check_read(2'd3, "R9 unmapped");
      // R6 hold through last stop bit
      do_write(2'd0, 8'h0B);
      set_in(1'b0, 1'b1, 1'b0); check_outputs();
      set_in(1'b0, 1'b0, 1'b1); check_outputs();
      set_in(1'b0, 1'b0, 1'b0); check_outputs();
      // R7 auto bit clear
      do_write(2'd1, 8'h00);
      set_in(1'b0, 1'b1, 1'b1); check_outputs();
      // R10 mode reg, write ignored
      do_write(2'd2, 8'hFF);
      check_read(2'd2, "R10 mode 485");
      check_read(2'd0, "R10 ctl untouched");
      iface_485 = 1'b0;
      check_read(2'd2, "R10 mode 232");
      // R3/R4/R5 directed
      do_write(2'd0, 8'h08); set_in(1'b0, 1'b0, 1'b0); check_outputs();
      do_write(2'd0, 8'h09); set_in(1'b1, 1'b0, 1'b0); check_outputs();
      set_in(1'b0, 1'b0, 1'b0); check_outputs();
      do_write(2'd0, 8'h0A); set_in(1'b1, 1'b0, 1'b0); check_outputs();
      set_in(1'b0, 1'b0, 1'b0); check_outputs();

      // random phase
      for (int i = 0; i < 400; i++) begin
         if (($urandom % 10) < 3) begin
            do_write(2'($urandom), 8'($urandom));
         end else begin
            set_in(1'($urandom), 1'($urandom), 1'($urandom));
            iface_485 = 1'($urandom);
         end
         check_outputs();
         check_read(2'($urandom), "R9 random read");
      end
      finish_run();
   end
endmodule